// File: doc/BRIEF.md
# Video-Mode Line and Frame Timing Generator

This block produces the line and frame skeleton for a video-mode serial display link. It runs on the lane byte clock. Each line is laid out from programmed durations counted in byte clocks: a horizontal sync interval, a back porch, an active payload window and a total line length. The front porch is never programmed. It is whatever is left of the line after sync, back porch and payload. Vertically, a frame is built from whole-line counts in a fixed order: sync lines, back-porch lines, active lines, then front-porch lines.

The block issues single-cycle phase strobes to a downstream packet assembler. These mark line start, sync end, payload start with the pixel count for the packet, and blanking start. It also issues frame start and frame end strobes, plus level hsync and vsync outputs with independently selectable polarity. A decoded video-mode type selects between non-burst with sync pulses, non-burst with sync events, and burst. The whole programmed set is captured into shadow registers at a frame boundary, so register writes made during a frame take effect only in the next frame.

Top module: `vlfg_top`

## Requirements
- R1: After reset, and whenever the generator is idle, every strobe is low and act_px is 0. hsync and vsync rest at their inactive level (the invert bit of the captured polarity). After reset the captured polarity is 0 and vmode reads 2 (burst).
- R2: A running line lasts cfg_hline byte clocks. hs_start pulses on the first clock of every line, and the raw sync level is active for the first cfg_hsa clocks of each line.
- R3: hs_end pulses at line clock cfg_hsa in the pulse mode (vmode 0) and in burst mode (vmode 2). It never pulses in the sync-event mode (vmode 1).
- R4: On active lines, act_start pulses at line clock cfg_hsa+cfg_hbp with act_px equal to the captured cfg_pixels, and blank_start pulses at clock cfg_hsa+cfg_hbp+cfg_hact, which starts the implicit front porch. On non-active lines, blank_start pulses at clock cfg_hsa+cfg_hbp and act_start stays low. act_px is 0 on every cycle without act_start.
- R5: A frame has cfg_vsa sync lines (raw vsync active), then cfg_vbp back-porch lines, then cfg_vact active lines, then cfg_vfp front-porch lines. frame_start pulses on the first clock of the first sync line, and frame_end pulses on the last clock of the last line.
- R6: A vertical sync request larger than 15 lines is clamped to 15 lines. A request of 15 or less is used as given.
- R7: cfg_pol bit 2 inverts hsync and cfg_pol bit 1 inverts vsync. Each output equals its raw active level XOR its invert bit.
- R8: cfg_flags bit 0 means video, bit 1 means burst and bit 2 means sync pulses. Video plus pulses without burst selects vmode 0. Video alone selects vmode 1. Every other combination selects vmode 2.
- R9: All cfg_* inputs are captured only when a frame starts. Changes made during a frame change nothing in that frame and apply from the next frame.
- R10: With the generator idle, enable sampled high starts a frame whose first clock is the next cycle. A frame whose last clock sees enable high is followed at once by a new frame. Dropping enable mid-frame lets the current frame finish, and the generator then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run request, sampled at frame boundaries |
| cfg_hsa | input | HW | Horizontal sync duration, byte clocks |
| cfg_hbp | input | HW | Horizontal back-porch duration, byte clocks |
| cfg_hact | input | HW | Payload window duration, byte clocks |
| cfg_hline | input | HW | Total line duration, byte clocks |
| cfg_pixels | input | PW | Pixel count reported with each payload start |
| cfg_vsa | input | VW | Vertical sync lines requested (clamped to 15) |
| cfg_vbp | input | VW | Vertical back-porch lines |
| cfg_vact | input | VW | Active lines |
| cfg_vfp | input | VW | Vertical front-porch lines |
| cfg_pol | input | 3 | Bit 2 inverts hsync, bit 1 inverts vsync |
| cfg_flags | input | 3 | Bit 0 video, bit 1 burst, bit 2 sync pulses |
| frame_start | output | 1 | First clock of a frame |
| frame_end | output | 1 | Last clock of a frame |
| hs_start | output | 1 | First clock of every line |
| hs_end | output | 1 | End of horizontal sync (pulse and burst modes) |
| act_start | output | 1 | Payload start on active lines |
| act_px | output | PW | Pixel count, valid with act_start, else 0 |
| blank_start | output | 1 | Start of blanking remainder of the line |
| hsync | output | 1 | Horizontal sync level after polarity |
| vsync | output | 1 | Vertical sync level after polarity |
| vmode | output | 2 | Captured video-mode type: 0 pulses, 1 events, 2 burst |

## Verification
The bench walks whole frames against an independent line and frame model. It targets the sync-end strobe in event mode, where a design that ignored the mode would emit a spurious hs_end. It targets the blank_start position, which moves between active and non-active lines; a design that computed the front porch only for active lines would miss the blanking packet on porch lines. It checks vertical sync requests of 15, 16 and 20: a design that truncated the request instead of clamping it would produce a 0- or 4-line sync. It also rewrites every register and the polarity partway through a frame and drops enable mid-frame. A design without frame-boundary capture would then produce a torn frame, and one that stopped at once on disable would cut the frame short with no frame_end.

// File: rtl/vlfg_pkg.sv
package vlfg_pkg;

   typedef enum logic [1:0] {
      VM_PULSE = 2'd0,
      VM_EVENT = 2'd1,
      VM_BURST = 2'd2
   } vmode_e;

   localparam int FLAG_VIDEO = 0;
   localparam int FLAG_BURST = 1;
   localparam int FLAG_PULSE = 2;

   localparam int POL_HINV = 2;
   localparam int POL_VINV = 1;

   localparam int VSA_MAX = 15;

   function automatic vmode_e decode_mode(input logic [2:0] f);
      vmode_e m;
      if (f[FLAG_VIDEO] && !f[FLAG_BURST] && f[FLAG_PULSE])
         m = VM_PULSE;
      else if (f[FLAG_VIDEO] && !f[FLAG_BURST] && !f[FLAG_PULSE])
         m = VM_EVENT;
      else
         m = VM_BURST;
      return m;
   endfunction

endpackage

// File: rtl/vlfg_shadow.sv
module vlfg_shadow
   import vlfg_pkg::*;
#(
   parameter int HW = 12,
   parameter int VW = 11,
   parameter int PW = 12,
   localparam int HSW = HW + 2,
   localparam int VSW = VW + 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [HW-1:0]  cfg_hsa,
   input  logic [HW-1:0]  cfg_hbp,
   input  logic [HW-1:0]  cfg_hact,
   input  logic [HW-1:0]  cfg_hline,
   input  logic [PW-1:0]  cfg_pixels,
   input  logic [VW-1:0]  cfg_vsa,
   input  logic [VW-1:0]  cfg_vbp,
   input  logic [VW-1:0]  cfg_vact,
   input  logic [VW-1:0]  cfg_vfp,
   input  logic [2:0]     cfg_pol,
   input  logic [2:0]     cfg_flags,
   output logic [HSW-1:0] h_sync_end,
   output logic [HSW-1:0] h_act_at,
   output logic [HSW-1:0] h_fp_at,
   output logic [HSW-1:0] h_line,
   output logic [PW-1:0]  pixels,
   output logic [VSW-1:0] v_bp_at,
   output logic [VSW-1:0] v_act_at,
   output logic [VSW-1:0] v_fp_at,
   output logic [VSW-1:0] v_tot,
   output logic           hinv,
   output logic           vinv,
   output vmode_e         mode
);

   logic [3:0]     vsa_lim;
   logic [HSW-1:0] h_a, h_b;
   logic [VSW-1:0] v_a, v_b, v_c;

   always_comb begin
      if (cfg_vsa > VW'(VSA_MAX))
         vsa_lim = 4'(VSA_MAX);
      else
         vsa_lim = cfg_vsa[3:0];
      h_a = HSW'(cfg_hsa) + HSW'(cfg_hbp);
      h_b = h_a + HSW'(cfg_hact);
      v_a = VSW'(vsa_lim) + VSW'(cfg_vbp);
      v_b = v_a + VSW'(cfg_vact);
      v_c = v_b + VSW'(cfg_vfp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_sync_end <= '0;
         h_act_at   <= '0;
         h_fp_at    <= '0;
         h_line     <= '0;
         pixels     <= '0;
         v_bp_at    <= '0;
         v_act_at   <= '0;
         v_fp_at    <= '0;
         v_tot      <= '0;
         hinv       <= 1'b0;
         vinv       <= 1'b0;
         mode       <= VM_BURST;
      end else if (load) begin
         h_sync_end <= HSW'(cfg_hsa);
         h_act_at   <= h_a;
         h_fp_at    <= h_b;
         h_line     <= HSW'(cfg_hline);
         pixels     <= cfg_pixels;
         v_bp_at    <= VSW'(vsa_lim);
         v_act_at   <= v_a;
         v_fp_at    <= v_b;
         v_tot      <= v_c;
         hinv       <= cfg_pol[POL_HINV];
         vinv       <= cfg_pol[POL_VINV];
         mode       <= decode_mode(cfg_flags);
      end
   end

endmodule

// File: rtl/vlfg_hcount.sv
module vlfg_hcount #(
   parameter int HSW = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic [HSW-1:0] h_sync_end,
   input  logic [HSW-1:0] h_act_at,
   input  logic [HSW-1:0] h_fp_at,
   input  logic [HSW-1:0] h_line,
   output logic           at_zero,
   output logic           at_sync_end,
   output logic           at_act,
   output logic           at_fp,
   output logic           in_sync,
   output logic           line_last
);

   logic [HSW-1:0] hcnt;

   always_comb begin
      line_last   = ({1'b0, hcnt} + (HSW+1)'(1)) >= {1'b0, h_line};
      at_zero     = (hcnt == '0);
      at_sync_end = (hcnt == h_sync_end);
      at_act      = (hcnt == h_act_at);
      at_fp       = (hcnt == h_fp_at);
      in_sync     = (hcnt < h_sync_end);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hcnt <= '0;
      else if (clear || line_last)
         hcnt <= '0;
      else
         hcnt <= hcnt + HSW'(1);
   end

endmodule

// File: rtl/vlfg_vcount.sv
module vlfg_vcount #(
   parameter int VSW = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           step,
   input  logic [VSW-1:0] v_bp_at,
   input  logic [VSW-1:0] v_act_at,
   input  logic [VSW-1:0] v_fp_at,
   input  logic [VSW-1:0] v_tot,
   output logic           first_line,
   output logic           last_line,
   output logic           in_vsync,
   output logic           act_line
);

   logic [VSW-1:0] vcnt;

   always_comb begin
      first_line = (vcnt == '0);
      last_line  = ({1'b0, vcnt} + (VSW+1)'(1)) >= {1'b0, v_tot};
      in_vsync   = (vcnt < v_bp_at);
      act_line   = (vcnt >= v_act_at) && (vcnt < v_fp_at);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vcnt <= '0;
      else if (clear)
         vcnt <= '0;
      else if (step)
         vcnt <= vcnt + VSW'(1);
   end

endmodule

// File: rtl/vlfg_top.sv
module vlfg_top
   import vlfg_pkg::*;
#(
   parameter int HW      = 12,
   parameter int VW      = 11,
   parameter int PW      = 12,
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [HW-1:0] cfg_hsa,
   input  logic [HW-1:0] cfg_hbp,
   input  logic [HW-1:0] cfg_hact,
   input  logic [HW-1:0] cfg_hline,
   input  logic [PW-1:0] cfg_pixels,
   input  logic [VW-1:0] cfg_vsa,
   input  logic [VW-1:0] cfg_vbp,
   input  logic [VW-1:0] cfg_vact,
   input  logic [VW-1:0] cfg_vfp,
   input  logic [2:0]    cfg_pol,
   input  logic [2:0]    cfg_flags,
   output logic          frame_start,
   output logic          frame_end,
   output logic          hs_start,
   output logic          hs_end,
   output logic          act_start,
   output logic [PW-1:0] act_px,
   output logic          blank_start,
   output logic          hsync,
   output logic          vsync,
   output logic [1:0]    vmode
);

   localparam int HSW = HW + 2;
   localparam int VSW = VW + 2;
   localparam int SHW = 4*HSW + PW + 4*VSW + 4;
   localparam int OBW = 9 + PW + 2;

   if (HW < 4) begin : g_bad_hw
      $error("vlfg_top: HW must be at least 4");
   end
   if (VW < 4) begin : g_bad_vw
      $error("vlfg_top: VW must be at least 4 to hold the sync cap");
   end
   if (PW < 1) begin : g_bad_pw
      $error("vlfg_top: PW must be at least 1");
   end

   logic [HSW-1:0] sh_hse, sh_hact, sh_hfp, sh_hline;
   logic [PW-1:0]  sh_px;
   logic [VSW-1:0] sh_vbp, sh_vact, sh_vfp, sh_vtot;
   logic           sh_hinv, sh_vinv;
   vmode_e         sh_mode;

   logic running, load, clear, frame_last;
   logic h_zero, h_se, h_act, h_fp, h_sync, h_last;
   logic v_first, v_last, v_sync, v_act;

   logic          s_fs, s_fe, s_hs, s_he, s_as, s_bs, s_hsync, s_vsync;
   logic          s_hs_raw, s_vs_raw, s_px_nz;
   logic [PW-1:0] s_px;
   logic [SHW-1:0] sh_bits;

   assign frame_last = running && h_last && v_last;
   assign load       = enable && (!running || frame_last);
   assign clear      = !running || frame_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         running <= 1'b0;
      else if (!running || frame_last)
         running <= enable;
   end

   vlfg_shadow #(.HW(HW), .VW(VW), .PW(PW)) u_shadow (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .cfg_hsa    (cfg_hsa),
      .cfg_hbp    (cfg_hbp),
      .cfg_hact   (cfg_hact),
      .cfg_hline  (cfg_hline),
      .cfg_pixels (cfg_pixels),
      .cfg_vsa    (cfg_vsa),
      .cfg_vbp    (cfg_vbp),
      .cfg_vact   (cfg_vact),
      .cfg_vfp    (cfg_vfp),
      .cfg_pol    (cfg_pol),
      .cfg_flags  (cfg_flags),
      .h_sync_end (sh_hse),
      .h_act_at   (sh_hact),
      .h_fp_at    (sh_hfp),
      .h_line     (sh_hline),
      .pixels     (sh_px),
      .v_bp_at    (sh_vbp),
      .v_act_at   (sh_vact),
      .v_fp_at    (sh_vfp),
      .v_tot      (sh_vtot),
      .hinv       (sh_hinv),
      .vinv       (sh_vinv),
      .mode       (sh_mode)
   );

   vlfg_hcount #(.HSW(HSW)) u_hcount (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .h_sync_end  (sh_hse),
      .h_act_at    (sh_hact),
      .h_fp_at     (sh_hfp),
      .h_line      (sh_hline),
      .at_zero     (h_zero),
      .at_sync_end (h_se),
      .at_act      (h_act),
      .at_fp       (h_fp),
      .in_sync     (h_sync),
      .line_last   (h_last)
   );

   vlfg_vcount #(.VSW(VSW)) u_vcount (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clear),
      .step       (h_last),
      .v_bp_at    (sh_vbp),
      .v_act_at   (sh_vact),
      .v_fp_at    (sh_vfp),
      .v_tot      (sh_vtot),
      .first_line (v_first),
      .last_line  (v_last),
      .in_vsync   (v_sync),
      .act_line   (v_act)
   );

   always_comb begin
      s_fs     = running && h_zero && v_first;
      s_fe     = frame_last;
      s_hs     = running && h_zero;
      s_he     = running && h_se && (sh_mode != VM_EVENT);
      s_as     = running && v_act && h_act;
      s_bs     = running && (v_act ? h_fp : h_act);
      s_px     = s_as ? sh_px : '0;
      s_px_nz  = |s_px;
      s_hs_raw = running && h_sync;
      s_vs_raw = running && v_sync;
      s_hsync  = s_hs_raw ^ sh_hinv;
      s_vsync  = s_vs_raw ^ sh_vinv;
      sh_bits  = {sh_hse, sh_hact, sh_hfp, sh_hline, sh_px,
                  sh_vbp, sh_vact, sh_vfp, sh_vtot,
                  sh_hinv, sh_vinv, sh_mode};
   end

   logic [OBW-1:0] obus;
   assign obus = {s_fs, s_fe, s_hs, s_he, s_as, s_bs, s_hsync, s_vsync,
                  1'b0, s_px, sh_mode};

   logic [OBW-1:0] obus_q;

   if (REG_OUT) begin : g_oreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            obus_q <= {{(OBW-2){1'b0}}, VM_BURST};
         else
            obus_q <= obus;
      end
   end else begin : g_ocomb
      assign obus_q = obus;
   end

   assign frame_start = obus_q[OBW-1];
   assign frame_end   = obus_q[OBW-2];
   assign hs_start    = obus_q[OBW-3];
   assign hs_end      = obus_q[OBW-4];
   assign act_start   = obus_q[OBW-5];
   assign blank_start = obus_q[OBW-6];
   assign hsync       = obus_q[OBW-7];
   assign vsync       = obus_q[OBW-8];
   assign act_px      = obus_q[PW+1:2];
   assign vmode       = obus_q[1:0];

   logic unused_pad;
   assign unused_pad = obus_q[OBW-9];

endmodule

// File: rtl/vlfg_checker.sv
module vlfg_checker #(
   parameter int SHW = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           enable,
   input logic           running,
   input logic           fs,
   input logic           fe,
   input logic           hs,
   input logic           he,
   input logic           as_s,
   input logic           px_nz,
   input logic           mode_event,
   input logic           vs_raw,
   input logic [SHW-1:0] sh_bits
);

   logic [4:0] vs_lines;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vs_lines <= '0;
      else if (fs)
         vs_lines <= (hs && vs_raw) ? 5'd1 : 5'd0;
      else if (hs && vs_raw && vs_lines != 5'd31)
         vs_lines <= vs_lines + 5'd1;
   end

   // R3: event mode never produces a sync-end strobe
   assert_no_hsend_in_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_event |-> !he);

   // R4: pixel count only travels with the payload start
   assert_px_only_with_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !as_s |-> !px_nz);

   // R5: a frame begins on a line start
   assert_frame_on_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fs |-> hs);

   // R6: never more than 15 sync lines in one frame
   assert_vsa_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vs_lines <= 5'd15);

   // R9: captured settings hold through the frame
   assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !fe) |=> $stable(sh_bits));

   // R10: enabled frame end is followed by a new frame
   assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fe && enable) |=> fs);

endmodule

bind vlfg_top vlfg_checker #(.SHW(SHW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .running    (running),
   .fs         (s_fs),
   .fe         (s_fe),
   .hs         (s_hs),
   .he         (s_he),
   .as_s       (s_as),
   .px_nz      (s_px_nz),
   .mode_event (sh_mode == vlfg_pkg::VM_EVENT),
   .vs_raw     (s_vs_raw),
   .sh_bits    (sh_bits)
);

// File: tb/vlfg_top_tb_top.sv
module vlfg_top_tb_top;

   localparam int HW = 12;
   localparam int VW = 11;
   localparam int PW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic [HW-1:0] cfg_hsa = '0, cfg_hbp = '0, cfg_hact = '0, cfg_hline = '0;
   logic [PW-1:0] cfg_pixels = '0;
   logic [VW-1:0] cfg_vsa = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
   logic [2:0]    cfg_pol = '0, cfg_flags = '0;

   logic          frame_start, frame_end, hs_start, hs_end, act_start, blank_start;
   logic          hsync, vsync;
   logic [PW-1:0] act_px;
   logic [1:0]    vmode;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   vlfg_top #(.HW(HW), .VW(VW), .PW(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hline(cfg_hline),
      .cfg_pixels(cfg_pixels), .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp),
      .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp), .cfg_pol(cfg_pol), .cfg_flags(cfg_flags),
      .frame_start(frame_start), .frame_end(frame_end), .hs_start(hs_start),
      .hs_end(hs_end), .act_start(act_start), .act_px(act_px),
      .blank_start(blank_start), .hsync(hsync), .vsync(vsync), .vmode(vmode)
   );

   function automatic logic [21:0] actual_vec();
      return {frame_start, frame_end, hs_start, hs_end, act_start, blank_start,
              hsync, vsync, vmode, act_px};
   endfunction

   task automatic compare(input logic [21:0] exp, input string tag);
      logic [21:0] act;
      act = actual_vec();
      vectors++;
      if (act !== exp) begin
         fails++;
         if (fails <= 20)
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_cfg(input int hsa, hbp, hact, hline, px, vsa, vbp, vact, vfp,
                          input logic [2:0] pol, input logic [2:0] flags);
      cfg_hsa = HW'(hsa); cfg_hbp = HW'(hbp); cfg_hact = HW'(hact);
      cfg_hline = HW'(hline); cfg_pixels = PW'(px);
      cfg_vsa = VW'(vsa); cfg_vbp = VW'(vbp); cfg_vact = VW'(vact); cfg_vfp = VW'(vfp);
      cfg_pol = pol; cfg_flags = flags;
   endtask

   // Walks one frame from the current negedge using the requirement model.
   task automatic check_frame(input int hsa, hbp, hact, hline, px, vsa_eff, vbp, vact, vfp,
                              input int mode, input bit hp, input bit vp, input string tag);
      int vtot;
      vtot = vsa_eff + vbp + vact + vfp;
      for (int v = 0; v < vtot; v++) begin
         for (int h = 0; h < hline; h++) begin
            bit al, as_e, bs_e;
            logic [21:0] e;
            al   = (v >= vsa_eff + vbp) && (v < vsa_eff + vbp + vact);
            as_e = al && (h == hsa + hbp);
            bs_e = al ? (h == hsa + hbp + hact) : (h == hsa + hbp);
            e = {(h == 0 && v == 0), (h == hline-1 && v == vtot-1), (h == 0),
                 (mode != 1 && h == hsa), as_e, bs_e,
                 ((h < hsa) ^ hp), ((v < vsa_eff) ^ vp), 2'(mode),
                 as_e ? PW'(px) : PW'(0)};
            compare(e, tag);
            @(negedge clk);
         end
      end
   endtask

   task automatic check_idle(input int n, input bit hp, input bit vp, input int mode,
                             input string tag);
      for (int i = 0; i < n; i++) begin
         compare({6'b0, hp, vp, 2'(mode), PW'(0)}, tag);
         @(negedge clk);
      end
   endtask

   task automatic run_one(input int hsa, hbp, hact, hline, px, vsa_req, vsa_eff, vbp, vact, vfp,
                          input logic [2:0] pol, input logic [2:0] flags, input int mode,
                          input string tag);
      set_cfg(hsa, hbp, hact, hline, px, vsa_req, vbp, vact, vfp, pol, flags);
      enable = 1'b1;
      @(negedge clk);
      fork
         check_frame(hsa, hbp, hact, hline, px, vsa_eff, vbp, vact, vfp,
                     mode, pol[2], pol[1], tag);
         begin
            repeat (4) @(negedge clk);
            enable = 1'b0;
         end
      join
      check_idle(4, pol[2], pol[1], mode, {tag, " idle R10"});
   endtask

   task automatic t_reset();
      check_idle(2, 1'b0, 1'b0, 2, "R1 in reset");
      rst_n = 1'b1;
      check_idle(4, 1'b0, 1'b0, 2, "R1 after reset");
   endtask

   task automatic t_pulse_two_frames();
      set_cfg(3, 4, 6, 20, 10, 2, 1, 3, 2, 3'b000, 3'b101);
      enable = 1'b1;
      @(negedge clk);
      check_frame(3, 4, 6, 20, 10, 2, 1, 3, 2, 0, 0, 0, "R2 R3 R4 R5 R8 pulse frame 1");
      fork
         check_frame(3, 4, 6, 20, 10, 2, 1, 3, 2, 0, 0, 0, "R10 back-to-back frame 2");
         begin
            repeat (10) @(negedge clk);
            enable = 1'b0;
         end
      join
      check_idle(6, 0, 0, 0, "R10 stop after frame end");
   endtask

   task automatic t_event_inverted();
      run_one(2, 3, 5, 16, 7, 1, 1, 2, 2, 1, 3'b110, 3'b001, 1, "R3 R7 R8 event inverted");
   endtask

   task automatic t_burst_variants();
      run_one(3, 4, 6, 20, 10, 2, 2, 1, 3, 2, 3'b100, 3'b011, 2, "R8 R7 burst 011");
      run_one(1, 1, 2, 6, 3, 1, 1, 1, 1, 1, 3'b000, 3'b111, 2, "R8 burst 111");
      run_one(1, 1, 2, 6, 3, 1, 1, 1, 1, 1, 3'b000, 3'b000, 2, "R8 burst 000");
      run_one(1, 1, 2, 6, 3, 1, 1, 1, 1, 1, 3'b010, 3'b100, 2, "R8 burst 100");
   endtask

   task automatic t_vsa_clamp();
      run_one(1, 1, 2, 6, 3, 20, 15, 1, 1, 1, 3'b000, 3'b101, 0, "R6 vsa 20 clamps to 15");
      run_one(1, 1, 2, 6, 3, 16, 15, 1, 1, 1, 3'b000, 3'b101, 0, "R6 vsa 16 clamps to 15");
      run_one(1, 1, 2, 6, 3, 15, 15, 1, 1, 1, 3'b010, 3'b101, 0, "R6 vsa 15 kept");
   endtask

   task automatic t_midframe_change();
      set_cfg(3, 4, 6, 20, 10, 2, 1, 3, 2, 3'b000, 3'b101);
      enable = 1'b1;
      @(negedge clk);
      fork
         check_frame(3, 4, 6, 20, 10, 2, 1, 3, 2, 0, 0, 0, "R9 old settings hold");
         begin
            repeat (30) @(negedge clk);
            set_cfg(2, 3, 5, 16, 7, 1, 2, 2, 1, 3'b110, 3'b001);
         end
      join
      fork
         check_frame(2, 3, 5, 16, 7, 1, 2, 2, 1, 1, 1, 1, "R9 new settings next frame");
         begin
            repeat (3) @(negedge clk);
            enable = 1'b0;
         end
      join
      check_idle(4, 1, 1, 1, "R9 R1 idle with captured polarity");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_pulse_two_frames();
      t_event_inverted();
      t_burst_variants();
      t_vsa_clamp();
      t_midframe_change();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

endmodule